// File: doc/BRIEF.md
# Logical Shift and Rotate Unit with Selectable Count Policy

This block shifts or rotates a 32-bit operand by a count taken from an 8-bit input. It offers logical left shift, logical right shift and left rotate, all with zero fill for the shifts. A single policy input decides how a shift treats counts of 32 or more. In wrap policy the count is cut down to its five low bits, which matches how common desktop processors behave. In full policy the whole count is used, so a large count empties the word.

Rotation is defined for every count and always turns by the count modulo 32, whichever policy is selected. The datapath is a pair of five-level logarithmic shifters, one for each direction. An optional output register adds one cycle of latency and carries a valid bit alongside the result.

Top module: `shift_policy_unit`

## Requirements
- R1: With op = 2'b00 the result is the operand shifted left by the effective count, with zeros entering at bit 0.
- R2: With op = 2'b01 the result is the operand shifted right by the effective count, with zeros entering at bit 31.
- R3: With op = 2'b10 the result is the operand rotated left by count modulo 32. A count whose low five bits are zero returns the operand unchanged.
- R4: With wrap_mode = 1, a shift (op 00 or 01) uses only count[4:0]. For example, a count of 32 leaves the operand unchanged, and a count of 33 acts as a count of 1.
- R5: With wrap_mode = 0, a shift (op 00 or 01) whose count is 32 or more gives a result of zero. Counts from 0 to 31 behave as in R1 and R2.
- R6: A rotate gives the same result for both values of wrap_mode.
- R7: op = 2'b11 is reserved and gives a result of zero.
- R8: With REGISTERED = 1, out_valid equals in_valid from the previous clock. The result register loads only when in_valid is high and otherwise holds its value. After reset, out_valid and result are both zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the output register |
| in_valid | input | 1 | Marks the inputs as a request to load |
| operand | input | 32 | Word to shift or rotate |
| count | input | 8 | Shift or rotate amount |
| op | input | 2 | 00 shift left, 01 shift right, 10 rotate left, 11 reserved |
| wrap_mode | input | 1 | 1 uses only count[4:0] for shifts; 0 uses the full count |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Shifted or rotated word |

## Verification
The hardest cases are counts of 32, 64 and higher multiples, where the five low bits are zero and the high bits are not. Here the two policies disagree most sharply: wrap policy returns the operand unchanged, while full policy returns zero. A rotate with the same count must also return the operand unchanged. The bench sweeps every count from 0 to 255 for all three operations under both policies, using operands with set bits at both ends of the word. This reaches every one of these multiples and every value of the upper count bits.

// File: rtl/shift_policy_unit.sv
module shift_policy_unit #(
  parameter int WIDTH      = 32,
  parameter int CNT_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] operand,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       op,
  input  logic             wrap_mode,
  output logic             out_valid,
  output logic [WIDTH-1:0] result
);
  localparam int SH_W = $clog2(WIDTH);

  localparam logic [1:0] OP_SHL = 2'b00;
  localparam logic [1:0] OP_SHR = 2'b01;
  localparam logic [1:0] OP_ROL = 2'b10;

  logic [SH_W-1:0] amt_l, amt_r, low_cnt;
  logic            high_set, kill;
  logic [WIDTH-1:0] lft [0:SH_W];
  logic [WIDTH-1:0] rgt [0:SH_W];
  logic [WIDTH-1:0] comb_res;

  assign low_cnt  = count[SH_W-1:0];
  assign high_set = |count[CNT_W-1:SH_W];
  assign amt_l    = low_cnt;
  assign amt_r    = (op == OP_ROL) ? SH_W'(0 - low_cnt) : low_cnt;
  assign kill     = !wrap_mode && high_set && (op != OP_ROL);

  assign lft[0] = operand;
  assign rgt[0] = operand;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    assign lft[i+1] = amt_l[i] ? (lft[i] << (1 << i)) : lft[i];
    assign rgt[i+1] = amt_r[i] ? (rgt[i] >> (1 << i)) : rgt[i];
  end

  always_comb begin
    case (op)
      OP_SHL:  comb_res = kill ? '0 : lft[SH_W];
      OP_SHR:  comb_res = kill ? '0 : rgt[SH_W];
      OP_ROL:  comb_res = lft[SH_W] | rgt[SH_W];
      default: comb_res = '0;
    endcase
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) result <= comb_res;
      end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid))); // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b11) |=> (result == '0)); // R7
    AST_FULL_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wrap_mode && |count[CNT_W-1:SH_W] && op[1] == 1'b0) |=> (result == '0)); // R5
    AST_ROT_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_ROL && count[SH_W-1:0] == '0) |=> (result == $past(operand))); // R3
    AST_WRAP_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wrap_mode && op[1] == 1'b0 && count[SH_W-1:0] == '0) |=> (result == $past(operand))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result)); // R8
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = comb_res;
  end
endmodule

// File: tb/shift_policy_unit_bench.sv
module shift_policy_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  count = '0;
  logic [1:0]  op = '0;
  logic        wrap_mode = 1'b0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shift_policy_unit u_shift_policy_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .count(count), .op(op), .wrap_mode(wrap_mode),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] model(logic [31:0] a, int c, logic [1:0] o, bit w);
    int e;
    logic [63:0] dbl;
    e = w ? (c % 32) : c;
    case (o)
      2'b00: return (e >= 32) ? 32'h0 : (a << e);
      2'b01: return (e >= 32) ? 32'h0 : (a >> e);
      2'b10: begin
        dbl = {a, a} << (c % 32);
        return dbl[63:32];
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, int c, logic [1:0] o, bit w);
    @(negedge clk);
    in_valid = 1'b1; operand = a; count = 8'(c); op = o; wrap_mode = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 reset valid", {31'h0, out_valid}, 32'h0);
    check("R8 reset result", result, 32'h0);
  endtask

  task automatic t_shl;
    apply(32'h8000_0001, 1, 2'b00, 1'b0); check("R1 shl 1", result, 32'h0000_0002);
    apply(32'h0000_00F0, 31, 2'b00, 1'b0); check("R1 shl 31", result, 32'h0000_0000);
    apply(32'h0000_0001, 31, 2'b00, 1'b0); check("R1 shl 31 msb", result, 32'h8000_0000);
  endtask

  task automatic t_shr;
    apply(32'h8000_0001, 4, 2'b01, 1'b1); check("R2 shr 4", result, 32'h0800_0000);
    apply(32'hFFFF_FFFF, 31, 2'b01, 1'b0); check("R2 shr 31", result, 32'h0000_0001);
  endtask

  task automatic t_rot;
    apply(32'h8000_0001, 1, 2'b10, 1'b0); check("R3 rol 1", result, 32'h0000_0003);
    apply(32'h1234_5678, 0, 2'b10, 1'b0); check("R3 rol 0", result, 32'h1234_5678);
    apply(32'h1234_5678, 8, 2'b10, 1'b1); check("R3 rol 8", result, 32'h3456_7812);
    apply(32'h1234_5678, 32, 2'b10, 1'b0); check("R6 rol 32 full", result, 32'h1234_5678);
    apply(32'h1234_5678, 36, 2'b10, 1'b0); check("R6 rol 36 full", result, 32'h2345_6781);
  endtask

  task automatic t_wrap;
    apply(32'hA5A5_0001, 32, 2'b00, 1'b1); check("R4 shl 32 wrap", result, 32'hA5A5_0001);
    apply(32'h0000_0001, 33, 2'b00, 1'b1); check("R4 shl 33 wrap", result, 32'h0000_0002);
    apply(32'h8000_0000, 255, 2'b01, 1'b1); check("R4 shr 255 wrap", result, 32'h0000_0001);
  endtask

  task automatic t_full;
    apply(32'hA5A5_0001, 32, 2'b00, 1'b0); check("R5 shl 32 full", result, 32'h0);
    apply(32'hFFFF_FFFF, 200, 2'b01, 1'b0); check("R5 shr 200 full", result, 32'h0);
    apply(32'hFFFF_FFFF, 64, 2'b01, 1'b0); check("R5 shr 64 full", result, 32'h0);
  endtask

  task automatic t_reserved;
    apply(32'hFFFF_FFFF, 3, 2'b11, 1'b1); check("R7 reserved", result, 32'h0);
  endtask

  task automatic t_idle;
    apply(32'h0000_00FF, 4, 2'b00, 1'b0);
    check("R8 valid after load", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    operand = 32'hDEAD_BEEF; count = 8'd1; op = 2'b01;
    @(negedge clk);
    check("R8 valid idle", {31'h0, out_valid}, 32'h0);
    check("R8 hold idle", result, 32'h0000_0FF0);
  endtask

  task automatic t_sweep;
    logic [31:0] pats [3] = '{32'h8000_0001, 32'hC3A5_5A3C, 32'hFFFF_FFFF};
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 2; w++)
        for (int o = 0; o < 3; o++)
          for (int c = 0; c < 256; c++) begin
            apply(pats[p], c, 2'(o), w[0]);
            case (o)
              0: check(w ? "R1 R4 sweep shl" : "R1 R5 sweep shl", result, model(pats[p], c, 2'(o), w[0]));
              1: check(w ? "R2 R4 sweep shr" : "R2 R5 sweep shr", result, model(pats[p], c, 2'(o), w[0]));
              default: check("R3 R6 sweep rol", result, model(pats[p], c, 2'(o), w[0]));
            endcase
          end
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_shl;
    t_shr;
    t_rot;
    t_wrap;
    t_full;
    t_reserved;
    t_idle;
    t_sweep;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule